// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block paces the clock line of an I2C master from the system clock. It drives the SCL level (1 releases the line, 0 pulls it low) and gives a byte engine single-cycle strobes at the phase points it needs: the SCL falling edge, the SCL release, the point where SDA may change after a programmable hold, and the point where SDA is sampled. It also filters glitches out of the SCL and SDA pins and returns the filtered levels.

Three speed modes are supported. Each mode has its own pair of high and low counts. The standard and fast modes share one spike-filter length and the high-speed mode has its own. The SCL rise and fall times are given in system-clock cycles and are added to the phases. The high phase is counted only after the filtered SCL has been seen high, so a target that holds SCL low stretches the clock. The block flags that case. Every setting is read live on each cycle, so software can reprogram the block while it runs.

Top module: `i2c_scl_timing`

## Requirements
- R1: `speed_mode` selects the count pair: 0 selects the standard pair, 1 the fast pair and 2 the high-speed pair. Value 3 behaves as standard. Modes 0, 1 and 3 use `fast_spike_len` and mode 2 uses `hs_spike_len`.
- R2: Each SCL low phase (`scl_out` = 0) lasts exactly low count + 1 + `scl_rise_cyc` cycles.
- R3: With `scl_in` following `scl_out` and no stretching, each SCL high phase lasts exactly high count + spike length + 7 + `scl_fall_cyc` cycles.
- R4: High-phase counting starts only after the filtered SCL is high. If a target holds SCL low for S extra cycles after release, the high phase grows by S. `scl_held` is asserted in that case and never without stretching.
- R5: A filtered line takes a new level only after the raw pin has differed from it on spike length + 1 consecutive cycles. Shorter pulses are rejected, and an accepted change appears exactly spike length + 1 cycles after it starts.
- R6: `scl_fall` pulses in the first low cycle and `scl_rise` pulses in the first released cycle. `sample` pulses once per high phase, spike length + 2 + S cycles after `scl_rise`.
- R7: `sda_change` pulses once per low phase, min(`sda_hold_cnt`, low phase length − 1) cycles after `scl_fall`.
- R8: One cycle after `enable` falls, `scl_out` is 1 with no strobes. One cycle after `enable` rises from idle, `scl_fall` pulses.
- R9: After reset, `scl_out`, `scl_filt` and `sda_filt` are 1 and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the SCL clock; 0 releases SCL and idles |
| speed_mode | input | 2 | 0 standard, 1 fast, 2 high speed, 3 as standard |
| std_high_cnt | input | 16 | Standard-mode high count |
| std_low_cnt | input | 16 | Standard-mode low count |
| fast_high_cnt | input | 16 | Fast-mode high count |
| fast_low_cnt | input | 16 | Fast-mode low count |
| hs_high_cnt | input | 16 | High-speed high count |
| hs_low_cnt | input | 16 | High-speed low count |
| fast_spike_len | input | 8 | Spike filter length, standard and fast modes |
| hs_spike_len | input | 8 | Spike filter length, high-speed mode |
| sda_hold_cnt | input | 16 | Cycles from SCL fall to the SDA change point |
| scl_fall_cyc | input | 8 | SCL fall time in cycles |
| scl_rise_cyc | input | 8 | SCL rise time in cycles |
| scl_in | input | 1 | Raw SCL pin level |
| sda_in | input | 1 | Raw SDA pin level |
| scl_out | output | 1 | SCL drive: 0 pulls low, 1 releases |
| scl_rise | output | 1 | First cycle of a released phase |
| scl_fall | output | 1 | First cycle of a low phase |
| sda_change | output | 1 | SDA may change in this cycle |
| sample | output | 1 | SDA is sampled in this cycle |
| scl_held | output | 1 | A target is holding SCL low after release |
| scl_filt | output | 1 | Glitch-filtered SCL |
| sda_filt | output | 1 | Glitch-filtered SDA |

## Verification
Some properties are checked on every cycle. A filtered line can only take the raw level from the previous cycle, and with a non-zero filter length only after two equal raw samples. A `sample` strobe only follows a cycle with the filtered SCL high. `scl_fall` only follows a released SCL. At most one edge or sample strobe is active at a time. A cycle after `enable` is low, SCL is released. The exact phase lengths, the positions of the SDA-change and sample points, the mode-to-register mapping, stretch extension and glitch rejection depend on how many cycles pass between events. Only the bench scenarios show these. The bench runs random settings for all four mode codes and adds directed cases with zero and oversized hold counts.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    // Fixed overheads of the phase counters, in system clock cycles
    localparam int LOW_FIXED  = 1;  // added to the low count
    localparam int HIGH_FIXED = 7;  // added to the high count (with spike len)
    localparam int WAIT_OVH   = 2;  // cycles the release takes to show through the filter

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        SEL_STD  = 2'd0,
        SEL_FAST = 2'd1,
        SEL_HS   = 2'd2
    } speed_sel_e;

    // The unused code 3 falls back to standard timing
    function automatic speed_sel_e decode_speed(input logic [1:0] code);
        case (code)
            2'd1:    return SEL_FAST;
            2'd2:    return SEL_HS;
            default: return SEL_STD;
        endcase
    endfunction

endpackage

// File: rtl/scl_glitch_filter.sv
module scl_glitch_filter
    import scl_timing_pkg::*;
#(
    parameter int SPK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SPK_W-1:0] spk_len_i,
    input  logic             raw_i,
    output logic             filt_o
);

    typedef struct packed {
        logic             filt;
        logic [SPK_W-1:0] run;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw_i == st_q.filt) begin
            st_d.run = '0;
        end else if (st_q.run >= spk_len_i) begin
            st_d.filt = raw_i;
            st_d.run  = '0;
        end else begin
            st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.filt <= 1'b1;
            st_q.run  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign filt_o = st_q.filt;

    // A new filtered level is always the level the pin had one cycle earlier
    assert_filt_takes_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.filt) |-> (st_q.filt == $past(raw_i)));

    // With a non-zero length, one differing sample never suffices
    assert_filt_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(st_q.filt) && ($past(spk_len_i) != '0)) |-> ($past(raw_i, 2) == $past(raw_i)));

endmodule

// File: rtl/scl_mode_select.sv
module scl_mode_select
    import scl_timing_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SPK_W  = 8,
    parameter int EDGE_W = 8,
    parameter int TOT_W  = CNT_W + 2
) (
    input  logic [1:0]        mode_i,
    input  logic [CNT_W-1:0]  std_hi_i,
    input  logic [CNT_W-1:0]  std_lo_i,
    input  logic [CNT_W-1:0]  fast_hi_i,
    input  logic [CNT_W-1:0]  fast_lo_i,
    input  logic [CNT_W-1:0]  hs_hi_i,
    input  logic [CNT_W-1:0]  hs_lo_i,
    input  logic [SPK_W-1:0]  fast_spk_i,
    input  logic [SPK_W-1:0]  hs_spk_i,
    input  logic [EDGE_W-1:0] fall_cyc_i,
    input  logic [EDGE_W-1:0] rise_cyc_i,
    output logic [TOT_W-1:0]  low_total_o,
    output logic [TOT_W-1:0]  high_count_o,
    output logic [SPK_W-1:0]  spk_o
);

    speed_sel_e       sel;
    logic [CNT_W-1:0] hi_cnt, lo_cnt;

    always_comb begin
        sel = decode_speed(mode_i);
        case (sel)
            SEL_FAST: begin
                hi_cnt = fast_hi_i;
                lo_cnt = fast_lo_i;
                spk_o  = fast_spk_i;
            end
            SEL_HS: begin
                hi_cnt = hs_hi_i;
                lo_cnt = hs_lo_i;
                spk_o  = hs_spk_i;
            end
            default: begin
                hi_cnt = std_hi_i;
                lo_cnt = std_lo_i;
                spk_o  = fast_spk_i;
            end
        endcase
        // Low phase: counted entirely by the phase counter
        low_total_o  = TOT_W'(lo_cnt) + TOT_W'(rise_cyc_i) + TOT_W'(LOW_FIXED);
        // High phase: the filter latency (spike length + WAIT_OVH) is spent
        // waiting for the release to show, the remainder is counted here
        high_count_o = TOT_W'(hi_cnt) + TOT_W'(fall_cyc_i) + TOT_W'(HIGH_FIXED - WAIT_OVH);
    end

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
    import scl_timing_pkg::*;
#(
    parameter int TOT_W  = 18,
    parameter int SPK_W  = 8,
    parameter int HOLD_W = 16,
    parameter int WAIT_W = SPK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              scl_filt_i,
    input  logic [TOT_W-1:0]  low_total_i,
    input  logic [TOT_W-1:0]  high_count_i,
    input  logic [SPK_W-1:0]  spk_i,
    input  logic [HOLD_W-1:0] hold_i,
    output logic              scl_o,
    output logic              scl_rise_o,
    output logic              scl_fall_o,
    output logic              sda_change_o,
    output logic              sample_o,
    output logic              held_o
);

    typedef struct packed {
        phase_e            ph;
        logic [TOT_W-1:0]  cnt;
        logic [WAIT_W-1:0] wcnt;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [TOT_W-1:0] hold_w, hold_eff;
    logic [WAIT_W:0]  held_lim;

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            PH_IDLE: begin
                if (en_i) begin
                    st_d.ph  = PH_LOW;
                    st_d.cnt = '0;
                end
            end
            PH_LOW: begin
                if (!en_i) begin
                    st_d.ph = PH_IDLE;
                end else if (st_q.cnt >= low_total_i - 1'b1) begin
                    st_d.ph   = PH_WAIT;
                    st_d.wcnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_WAIT: begin
                if (!en_i) begin
                    st_d.ph = PH_IDLE;
                end else if (scl_filt_i) begin
                    st_d.ph  = PH_HIGH;
                    st_d.cnt = '0;
                end else if (st_q.wcnt != '1) begin
                    st_d.wcnt = st_q.wcnt + 1'b1;
                end
            end
            default: begin
                if (!en_i) begin
                    st_d.ph = PH_IDLE;
                end else if (st_q.cnt >= high_count_i - 1'b1) begin
                    st_d.ph  = PH_LOW;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= PH_IDLE;
            st_q.cnt  <= '0;
            st_q.wcnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        hold_w   = TOT_W'(hold_i);
        hold_eff = (hold_w >= low_total_i) ? (low_total_i - 1'b1) : hold_w;
        held_lim = (WAIT_W+1)'(spk_i) + (WAIT_W+1)'(WAIT_OVH);
    end

    assign scl_o        = (st_q.ph != PH_LOW);
    assign scl_fall_o   = (st_q.ph == PH_LOW)  && (st_q.cnt == '0);
    assign scl_rise_o   = (st_q.ph == PH_WAIT) && (st_q.wcnt == '0);
    assign sample_o     = (st_q.ph == PH_HIGH) && (st_q.cnt == '0);
    assign sda_change_o = (st_q.ph == PH_LOW)  && (st_q.cnt == hold_eff);
    assign held_o       = (st_q.ph == PH_WAIT) && ((WAIT_W+1)'(st_q.wcnt) >= held_lim);

    assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en_i) |-> (scl_o && !scl_fall_o && !scl_rise_o && !sample_o));

    assert_sample_after_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> $past(scl_filt_i));

    assert_fall_from_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_o |-> $past(scl_o));

    assert_strobes_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise_o, scl_fall_o, sample_o}));

endmodule

// File: rtl/i2c_scl_timing.sv
module i2c_scl_timing
    import scl_timing_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int SPK_W  = 8,
    parameter int EDGE_W = 8,
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        speed_mode,
    input  logic [CNT_W-1:0]  std_high_cnt,
    input  logic [CNT_W-1:0]  std_low_cnt,
    input  logic [CNT_W-1:0]  fast_high_cnt,
    input  logic [CNT_W-1:0]  fast_low_cnt,
    input  logic [CNT_W-1:0]  hs_high_cnt,
    input  logic [CNT_W-1:0]  hs_low_cnt,
    input  logic [SPK_W-1:0]  fast_spike_len,
    input  logic [SPK_W-1:0]  hs_spike_len,
    input  logic [HOLD_W-1:0] sda_hold_cnt,
    input  logic [EDGE_W-1:0] scl_fall_cyc,
    input  logic [EDGE_W-1:0] scl_rise_cyc,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_out,
    output logic              scl_rise,
    output logic              scl_fall,
    output logic              sda_change,
    output logic              sample,
    output logic              scl_held,
    output logic              scl_filt,
    output logic              sda_filt
);

    localparam int TOT_W   = ((CNT_W > EDGE_W) ? CNT_W : EDGE_W) + 2;
    localparam int N_LINES = 2;   // index 0 = SCL, 1 = SDA

    logic [TOT_W-1:0]   low_total, high_count;
    logic [SPK_W-1:0]   spk_sel;
    logic [N_LINES-1:0] line_raw, line_filt;

    scl_mode_select #(
        .CNT_W (CNT_W),
        .SPK_W (SPK_W),
        .EDGE_W(EDGE_W),
        .TOT_W (TOT_W)
    ) u_mode (
        .mode_i      (speed_mode),
        .std_hi_i    (std_high_cnt),
        .std_lo_i    (std_low_cnt),
        .fast_hi_i   (fast_high_cnt),
        .fast_lo_i   (fast_low_cnt),
        .hs_hi_i     (hs_high_cnt),
        .hs_lo_i     (hs_low_cnt),
        .fast_spk_i  (fast_spike_len),
        .hs_spk_i    (hs_spike_len),
        .fall_cyc_i  (scl_fall_cyc),
        .rise_cyc_i  (scl_rise_cyc),
        .low_total_o (low_total),
        .high_count_o(high_count),
        .spk_o       (spk_sel)
    );

    assign line_raw = {sda_in, scl_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        scl_glitch_filter #(.SPK_W(SPK_W)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .spk_len_i(spk_sel),
            .raw_i    (line_raw[g]),
            .filt_o   (line_filt[g])
        );
    end

    assign scl_filt = line_filt[0];
    assign sda_filt = line_filt[1];

    scl_phase_ctrl #(
        .TOT_W (TOT_W),
        .SPK_W (SPK_W),
        .HOLD_W(HOLD_W)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (enable),
        .scl_filt_i  (line_filt[0]),
        .low_total_i (low_total),
        .high_count_i(high_count),
        .spk_i       (spk_sel),
        .hold_i      (sda_hold_cnt),
        .scl_o       (scl_out),
        .scl_rise_o  (scl_rise),
        .scl_fall_o  (scl_fall),
        .sda_change_o(sda_change),
        .sample_o    (sample),
        .held_o      (scl_held)
    );

endmodule

// File: tb/test_i2c_scl_timing.sv
module test_i2c_scl_timing;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  speed_mode = 2'd0;
    logic [15:0] std_hi = 16'd10, std_lo = 16'd20;
    logic [15:0] fast_hi = 16'd10, fast_lo = 16'd20;
    logic [15:0] hs_hi = 16'd10, hs_lo = 16'd20;
    logic [7:0]  fast_spk = 8'd0, hs_spk = 8'd0;
    logic [15:0] hold = 16'd0;
    logic [7:0]  fall_cyc = 8'd0, rise_cyc = 8'd0;
    logic        stretch = 1'b0;
    logic        sda_in = 1'b1;
    logic        scl_in;
    logic        scl_out, scl_rise, scl_fall, sda_change, sample, scl_held, scl_filt, sda_filt;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    // The target side: pin follows the driver unless the bench stretches
    assign scl_in = scl_out & ~stretch;

    i2c_scl_timing i_i2c_scl_timing (
        .clk(clk), .rst_n(rst_n), .enable(enable), .speed_mode(speed_mode),
        .std_high_cnt(std_hi), .std_low_cnt(std_lo),
        .fast_high_cnt(fast_hi), .fast_low_cnt(fast_lo),
        .hs_high_cnt(hs_hi), .hs_low_cnt(hs_lo),
        .fast_spike_len(fast_spk), .hs_spike_len(hs_spk),
        .sda_hold_cnt(hold), .scl_fall_cyc(fall_cyc), .scl_rise_cyc(rise_cyc),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_out(scl_out), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_change(sda_change), .sample(sample), .scl_held(scl_held),
        .scl_filt(scl_filt), .sda_filt(sda_filt)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model of the requirements
    function automatic int eff_spk(input logic [1:0] m);
        return (m == 2'd2) ? int'(hs_spk) : int'(fast_spk);
    endfunction
    function automatic int sel_hi(input logic [1:0] m);
        return (m == 2'd1) ? int'(fast_hi) : (m == 2'd2) ? int'(hs_hi) : int'(std_hi);
    endfunction
    function automatic int sel_lo(input logic [1:0] m);
        return (m == 2'd1) ? int'(fast_lo) : (m == 2'd2) ? int'(hs_lo) : int'(std_lo);
    endfunction
    function automatic int exp_low(input logic [1:0] m);
        return sel_lo(m) + 1 + int'(rise_cyc);
    endfunction
    function automatic int exp_high(input logic [1:0] m, input int s);
        return sel_hi(m) + eff_spk(m) + 7 + int'(fall_cyc) + s;
    endfunction
    function automatic int exp_sda(input logic [1:0] m);
        return (int'(hold) >= exp_low(m)) ? exp_low(m) - 1 : int'(hold);
    endfunction

    // One full SCL period from enable; optional stretch of s cycles
    task automatic run_period(input int s);
        int lo = 0, hi = 0, sda_at = -1, samp_at = -1, held_seen = 0;
        stretch = (s > 0);
        @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
        check("R8 scl_fall one cycle after enable", int'(scl_fall), 1);
        while (scl_out == 1'b0) begin
            if (sda_change && sda_at < 0) sda_at = lo;
            lo++;
            @(negedge clk);
        end
        check("R6 scl_rise on first released cycle", int'(scl_rise), 1);
        while (scl_out == 1'b1) begin
            if (hi == s) stretch = 1'b0;
            if (sample && samp_at < 0) samp_at = hi;
            if (scl_held) held_seen = 1;
            hi++;
            @(negedge clk);
        end
        check("R2 low phase length (R1 mode pair)", lo, exp_low(speed_mode));
        check("R3/R4 high phase length (R1 mode pair)", hi, exp_high(speed_mode, s));
        check("R7 sda_change offset", sda_at, exp_sda(speed_mode));
        check("R6 sample offset", samp_at, eff_spk(speed_mode) + 2 + s);
        check("R4 scl_held flag", held_seen, (s > 0) ? 1 : 0);
        enable = 1'b0;
        @(negedge clk);
        check("R8 released after disable", int'(scl_out), 1);
        check("R8 no strobes after disable",
              int'({scl_fall, scl_rise, sample, sda_change}), 0);
        repeat (4) @(negedge clk);
    endtask

    // Low pulse of w cycles on SDA with the filter of mode m
    task automatic glitch(input int w);
        int lat = -1, i = 0, spk = eff_spk(speed_mode);
        @(negedge clk);
        sda_in = 1'b0;
        for (int k = 0; k < w; k++) begin
            @(negedge clk);
            i++;
            if (!sda_filt && lat < 0) lat = i;
        end
        sda_in = 1'b1;
        for (int k = 0; k < 2 * spk + 6; k++) begin
            @(negedge clk);
            if (!sda_filt && lat < 0) lat = 999;
        end
        if (w >= spk + 1) check("R5 accepted pulse latency", lat, spk + 1);
        else              check("R5 short pulse rejected", lat, -1);
        check("R5 filtered SDA back high", int'(sda_filt), 1);
    endtask

    task automatic randomize_cfg();
        std_hi   = 16'($urandom_range(0, 40));
        std_lo   = 16'($urandom_range(10, 50));
        fast_hi  = 16'($urandom_range(0, 40));
        fast_lo  = 16'($urandom_range(10, 50));
        hs_hi    = 16'($urandom_range(0, 40));
        hs_lo    = 16'($urandom_range(10, 50));
        fast_spk = 8'($urandom_range(0, 6));
        hs_spk   = 8'($urandom_range(0, 6));
        fall_cyc = 8'($urandom_range(0, 7));
        rise_cyc = 8'($urandom_range(0, 7));
        hold     = 16'($urandom_range(0, 70));
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 scl_out after reset", int'(scl_out), 1);
        check("R9 strobes after reset",
              int'({scl_fall, scl_rise, sample, sda_change, scl_held}), 0);
        check("R9 filtered lines after reset", int'({scl_filt, sda_filt}), 3);

        // Directed: each mode code, no stretch, distinct pairs (R1)
        for (int m = 0; m < 4; m++) begin
            randomize_cfg();
            speed_mode = 2'(m);
            run_period(0);
        end
        // Directed: zero hold and oversized hold (R7)
        randomize_cfg();
        speed_mode = 2'd1;
        hold = 16'd0;
        run_period(0);
        hold = 16'd500;
        run_period(0);
        // Directed: stretch in high-speed mode and in mode 3 (R4, R1)
        randomize_cfg();
        speed_mode = 2'd2;
        run_period(5);
        speed_mode = 2'd3;
        run_period(1);

        // Random periods
        for (int t = 0; t < 30; t++) begin
            randomize_cfg();
            speed_mode = 2'($urandom_range(0, 3));
            run_period(($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 10)) : 0);
        end

        // Filter behaviour on SDA (R5), including mode 3 selecting fast length (R1)
        fast_spk = 8'd3;
        hs_spk   = 8'd6;
        speed_mode = 2'd3;
        glitch(3);
        glitch(4);
        speed_mode = 2'd2;
        glitch(6);
        glitch(7);
        glitch(12);
        fast_spk = 8'd0;
        speed_mode = 2'd0;
        glitch(1);
        for (int t = 0; t < 10; t++) begin
            fast_spk = 8'($urandom_range(0, 6));
            hs_spk   = 8'($urandom_range(0, 6));
            speed_mode = 2'($urandom_range(0, 3));
            glitch(int'($urandom_range(1, 9)));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule